// File: doc/BRIEF.md
# Instruction-Trace Packet Parser

This block sits at the front of an instruction-trace decoder. It takes a byte-serial trace stream, one byte per accepted cycle, and splits it into packets. After reset it is unsynchronised and drops every byte until an alignment run appears. From then on each byte in header position selects a packet class, and the parser collects the payload bytes that class needs. Some classes have a fixed length. Short addresses and trace-info packets get their length from continuation bits.

For every completed packet it raises a one-cycle strobe carrying:

- a kind code,
- the payload bytes collected so far, packed low byte first,
- the payload byte count.

For atom packets the strobe also carries an expanded list of taken/not-taken flags. A later block rebuilds addresses from the raw payload. A header the parser does not know raises an error strobe, and the parser falls back to hunting for alignment.

Top module: `trc_pkt_parser`

## Requirements
- R1: While reset is held, `synced`, `pkt_valid`, `err` and `in_ready` are all 0. From the first clock after reset is released, `in_ready` is 1. A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1.
- R2: While unsynchronised, taken bytes are discarded with no strobe. A run of at least 11 consecutive 0x00 bytes followed by 0x80 produces one packet of kind 0 (alignment) with length 0 and sets `synced`. A shorter zero run followed by 0x80 does nothing.
- R3: Header 0x04 produces a kind 2 (trace on) packet of length 0. Every packet strobe and every error strobe appears in the cycle after the edge that took the packet's last byte.
- R4: Headers 0xF8 to 0xFF give a kind 3 (atom) packet with length 0 and `atom_count` 3. `atom_flags` bit i is atom i, counted from the oldest at bit 0, and equals header bit i. A 1 means taken.
- R5: Headers 0xDC to 0xDF give a kind 3 packet with `atom_count` 4. The flags come from header bits 1:0, written oldest first: 00 gives taken, taken, taken, not; 01 gives four not-taken; 10 gives taken, not, taken, not; 11 gives not, taken, not, taken.
- R6: Header 0x9D collects 8 payload bytes as kind 6. Header 0x9A collects 4 as kind 5. Payload byte i, counted in arrival order after the header, appears at `pkt_payload[8*i+7:8*i]`. Unfilled bytes are 0. `atom_count` and `atom_flags` are 0 for every non-atom packet.
- R7: Header 0x85 collects 8 address bytes and then one context byte as a kind 7 packet of length 9. The context byte sits at payload byte 8.
- R8: Header 0x95 is a kind 4 short address. If bit 7 of its first payload byte is clear, the packet ends there with length 1. If it is set, exactly one more byte follows and the length is 2.
- R9: Header 0x01 is a kind 1 trace-info packet. Its first payload byte is a control byte, and each set bit among its bits 3:0 opens one field. A field ends at the first byte whose bit 7 is clear. The packet ends when the control byte opens no field or when the last open field ends. The length counts the control byte and all field bytes.
- R10: Any header other than 0x00, 0x01, 0x04, 0x85, 0x95, 0x9A, 0x9D, 0xDC–0xDF or 0xF8–0xFF gives an `err` strobe instead of a packet and clears `synced`. Later bytes are discarded until R2 is met again.
- R11: While synchronised, a 0x00 header starts an in-stream alignment. Further 0x00 bytes are absorbed. A 0x80 that ends a run of at least 11 zeros counted from that header gives a kind 0 packet. Any other byte gives an `err` strobe and clears `synced`.
- R12: A trace-info payload longer than 9 bytes gives an `err` strobe on the tenth payload byte and clears `synced`.
- R13: `pkt_valid` and `err` are never 1 in the same cycle, and `pkt_valid` is only 1 while `synced` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Trace stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| synced | output | 1 | Parser is aligned to packet boundaries |
| pkt_valid | output | 1 | One-cycle strobe: a packet completed |
| pkt_kind | output | 3 | Packet kind code (0 to 7) |
| pkt_len | output | 4 | Payload byte count |
| pkt_payload | output | 72 | Payload bytes, first byte in bits 7:0 |
| atom_count | output | 3 | Number of atoms in an atom packet, else 0 |
| atom_flags | output | 4 | Atom outcomes, oldest at bit 0, 1 = taken |
| err | output | 1 | One-cycle strobe: bad header, broken alignment or overlong payload |

## Verification
Most internal faults in this parser are framing faults: a wrong collection count or a state that is not left on time. Such a fault shifts every later header by one or more bytes. The very next expected packet therefore appears with the wrong kind or length, or turns into an error strobe, one cycle after its last byte should have been taken. A wrong zero-run count shows up at the first 0x80: the alignment packet is missing, or it appears after too short a run. The bench compares each strobe in order against a queue of expected packets, so any slip is reported at the first packet it affects.

// File: rtl/trc_pkg.sv
package trc_pkg;

    // Packet kind codes presented on pkt_kind
    typedef enum logic [2:0] {
        PK_SYNC    = 3'd0,
        PK_TINFO   = 3'd1,
        PK_TON     = 3'd2,
        PK_ATOM    = 3'd3,
        PK_SADDR   = 3'd4,
        PK_LADDR32 = 3'd5,
        PK_LADDR64 = 3'd6,
        PK_ACTX64  = 3'd7
    } pkt_kind_e;

    // Parser states; ST_HUNT must stay at code 0 (reset value)
    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ZRUN   = 3'd2,
        ST_FIXED  = 3'd3,
        ST_SHORT  = 3'd4,
        ST_TCTL   = 3'd5,
        ST_TFIELD = 3'd6
    } parse_st_e;

    // Header classes produced by the header decoder
    typedef enum logic [2:0] {
        HC_BAD   = 3'd0,
        HC_ZERO  = 3'd1,
        HC_TINFO = 3'd2,
        HC_ONE   = 3'd3,
        HC_ATOM  = 3'd4,
        HC_FIXED = 3'd5,
        HC_SHORT = 3'd6
    } hdr_class_e;

endpackage

// File: rtl/trc_sync_hunter.sv
module trc_sync_hunter #(
    parameter int ZEROS = 11,
    parameter int CW    = $clog2(ZEROS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       restart,
    input  logic [7:0] data,
    output logic       found
);

    logic [CW-1:0] run_d, run_q;

    // Zero-run length, saturating at ZEROS; restart begins a new run at a header
    always_comb begin
        run_d = run_q;
        if (beat) begin
            if (data != 8'h00)
                run_d = '0;
            else if (restart)
                run_d = CW'(1);
            else if (run_q != CW'(ZEROS))
                run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= run_d;
    end

    assign found = beat && !restart && (data == 8'h80) && (run_q == CW'(ZEROS));

    assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(ZEROS));

    assert_run_cleared_after_find_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> (run_q == '0));

endmodule

// File: rtl/trc_hdr_decode.sv
module trc_hdr_decode
    import trc_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [7:0]       hdr,
    output hdr_class_e       cls,
    output pkt_kind_e        kind,
    output logic [LEN_W-1:0] fixed_len
);

    always_comb begin
        cls       = HC_BAD;
        kind      = PK_SYNC;
        fixed_len = '0;
        if (hdr == 8'h00) begin
            cls  = HC_ZERO;
            kind = PK_SYNC;
        end else if (hdr == 8'h01) begin
            cls  = HC_TINFO;
            kind = PK_TINFO;
        end else if (hdr == 8'h04) begin
            cls  = HC_ONE;
            kind = PK_TON;
        end else if (hdr[7:3] == 5'b11111 || hdr[7:2] == 6'b110111) begin
            cls  = HC_ATOM;
            kind = PK_ATOM;
        end else if (hdr == 8'h9D) begin
            cls       = HC_FIXED;
            kind      = PK_LADDR64;
            fixed_len = LEN_W'(8);
        end else if (hdr == 8'h9A) begin
            cls       = HC_FIXED;
            kind      = PK_LADDR32;
            fixed_len = LEN_W'(4);
        end else if (hdr == 8'h85) begin
            cls       = HC_FIXED;
            kind      = PK_ACTX64;
            fixed_len = LEN_W'(9);
        end else if (hdr == 8'h95) begin
            cls  = HC_SHORT;
            kind = PK_SADDR;
        end
    end

endmodule

// File: rtl/trc_atom_expand.sv
module trc_atom_expand #(
    parameter int MAX_ATOMS = 4,
    parameter int CW        = $clog2(MAX_ATOMS + 1)
) (
    input  logic [7:0]           hdr,
    output logic [CW-1:0]        count,
    output logic [MAX_ATOMS-1:0] e_flags
);

    // Flags are listed oldest atom first at bit 0; 1 marks a taken atom
    always_comb begin
        count   = '0;
        e_flags = '0;
        if (hdr[7:3] == 5'b11111) begin
            count   = CW'(3);
            e_flags = MAX_ATOMS'(hdr[2:0]);
        end else if (hdr[7:2] == 6'b110111) begin
            count = CW'(4);
            case (hdr[1:0])
                2'b00:   e_flags = MAX_ATOMS'(4'b0111);
                2'b01:   e_flags = MAX_ATOMS'(4'b0000);
                2'b10:   e_flags = MAX_ATOMS'(4'b0101);
                default: e_flags = MAX_ATOMS'(4'b1010);
            endcase
        end
    end

endmodule

// File: rtl/trc_pkt_parser.sv
module trc_pkt_parser
    import trc_pkg::*;
#(
    parameter int PAY_MAX    = 9,
    parameter int SYNC_ZEROS = 11,
    parameter int MAX_ATOMS  = 4,
    parameter int LEN_W      = $clog2(PAY_MAX + 1),
    parameter int PAY_W      = PAY_MAX * 8,
    parameter int ACNT_W     = $clog2(MAX_ATOMS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 synced,
    output logic                 pkt_valid,
    output logic [2:0]           pkt_kind,
    output logic [LEN_W-1:0]     pkt_len,
    output logic [PAY_W-1:0]     pkt_payload,
    output logic [ACNT_W-1:0]    atom_count,
    output logic [MAX_ATOMS-1:0] atom_flags,
    output logic                 err
);

    localparam int FW = 3;  // open trace-info field counter (up to 4)

    typedef struct packed {
        parse_st_e             st;
        logic [LEN_W-1:0]      left;
        logic [FW-1:0]         fields;
        logic [LEN_W-1:0]      len;
        logic [PAY_W-1:0]      pay;
        pkt_kind_e             kind;
        logic [ACNT_W-1:0]     acnt;
        logic [MAX_ATOMS-1:0]  ae;
        logic                  ev_pkt;
        logic                  ev_err;
        logic                  rdy;
    } regs_t;

    regs_t r_d, r_q;

    logic                 beat;
    logic                 sync_found;
    logic                 full;
    logic [PAY_W-1:0]     pay_ins;
    logic [LEN_W-1:0]     len_inc;
    hdr_class_e           h_cls;
    pkt_kind_e            h_kind;
    logic [LEN_W-1:0]     h_len;
    logic [ACNT_W-1:0]    a_cnt;
    logic [MAX_ATOMS-1:0] a_flags;

    assign beat    = in_valid && r_q.rdy;
    assign full    = (r_q.len == LEN_W'(PAY_MAX));
    assign pay_ins = r_q.pay | (PAY_W'(in_data) << {r_q.len, 3'b000});
    assign len_inc = r_q.len + 1'b1;

    trc_sync_hunter #(
        .ZEROS (SYNC_ZEROS)
    ) u_hunter (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (beat),
        .restart (r_q.st == ST_IDLE),
        .data    (in_data),
        .found   (sync_found)
    );

    trc_hdr_decode #(
        .LEN_W (LEN_W)
    ) u_hdr (
        .hdr       (in_data),
        .cls       (h_cls),
        .kind      (h_kind),
        .fixed_len (h_len)
    );

    trc_atom_expand #(
        .MAX_ATOMS (MAX_ATOMS),
        .CW        (ACNT_W)
    ) u_atoms (
        .hdr     (in_data),
        .count   (a_cnt),
        .e_flags (a_flags)
    );

    always_comb begin
        r_d        = r_q;
        r_d.ev_pkt = 1'b0;
        r_d.ev_err = 1'b0;
        r_d.rdy    = 1'b1;
        if (beat) begin
            case (r_q.st)
                ST_HUNT: begin
                    if (sync_found) begin
                        r_d.kind   = PK_SYNC;
                        r_d.len    = '0;
                        r_d.pay    = '0;
                        r_d.acnt   = '0;
                        r_d.ae     = '0;
                        r_d.ev_pkt = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    r_d.kind = h_kind;
                    r_d.len  = '0;
                    r_d.pay  = '0;
                    r_d.acnt = a_cnt;
                    r_d.ae   = a_flags;
                    case (h_cls)
                        HC_ZERO:  r_d.st = ST_ZRUN;
                        HC_TINFO: r_d.st = ST_TCTL;
                        HC_ONE,
                        HC_ATOM:  r_d.ev_pkt = 1'b1;
                        HC_FIXED: begin
                            r_d.st   = ST_FIXED;
                            r_d.left = h_len;
                        end
                        HC_SHORT: r_d.st = ST_SHORT;
                        default: begin
                            r_d.ev_err = 1'b1;
                            r_d.st     = ST_HUNT;
                        end
                    endcase
                end
                ST_ZRUN: begin
                    if (sync_found) begin
                        r_d.ev_pkt = 1'b1;
                        r_d.st     = ST_IDLE;
                    end else if (in_data != 8'h00) begin
                        r_d.ev_err = 1'b1;
                        r_d.st     = ST_HUNT;
                    end
                end
                ST_FIXED: begin
                    if (full) begin
                        r_d.ev_err = 1'b1;
                        r_d.st     = ST_HUNT;
                    end else begin
                        r_d.pay  = pay_ins;
                        r_d.len  = len_inc;
                        r_d.left = r_q.left - 1'b1;
                        if (r_q.left == LEN_W'(1)) begin
                            r_d.ev_pkt = 1'b1;
                            r_d.st     = ST_IDLE;
                        end
                    end
                end
                ST_SHORT: begin
                    if (full) begin
                        r_d.ev_err = 1'b1;
                        r_d.st     = ST_HUNT;
                    end else begin
                        r_d.pay = pay_ins;
                        r_d.len = len_inc;
                        if (!in_data[7] || r_q.len != '0) begin
                            r_d.ev_pkt = 1'b1;
                            r_d.st     = ST_IDLE;
                        end
                    end
                end
                ST_TCTL: begin
                    if (full) begin
                        r_d.ev_err = 1'b1;
                        r_d.st     = ST_HUNT;
                    end else begin
                        r_d.pay    = pay_ins;
                        r_d.len    = len_inc;
                        r_d.fields = FW'($countones(in_data[3:0]));
                        if (r_d.fields == '0) begin
                            r_d.ev_pkt = 1'b1;
                            r_d.st     = ST_IDLE;
                        end else begin
                            r_d.st = ST_TFIELD;
                        end
                    end
                end
                ST_TFIELD: begin
                    if (full) begin
                        r_d.ev_err = 1'b1;
                        r_d.st     = ST_HUNT;
                    end else begin
                        r_d.pay = pay_ins;
                        r_d.len = len_inc;
                        if (!in_data[7]) begin
                            r_d.fields = r_q.fields - 1'b1;
                            if (r_q.fields == FW'(1)) begin
                                r_d.ev_pkt = 1'b1;
                                r_d.st     = ST_IDLE;
                            end
                        end
                    end
                end
                default: begin
                    r_d.ev_err = 1'b1;
                    r_d.st     = ST_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign in_ready    = r_q.rdy;
    assign synced      = (r_q.st != ST_HUNT);
    assign pkt_valid   = r_q.ev_pkt;
    assign pkt_kind    = r_q.kind;
    assign pkt_len     = r_q.len;
    assign pkt_payload = r_q.pay;
    assign atom_count  = r_q.acnt;
    assign atom_flags  = r_q.ae;
    assign err         = r_q.ev_err;

    assert_no_dual_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && err));

    assert_pkt_only_synced_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> synced);

    assert_err_unsyncs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !synced);

    assert_len_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len <= LEN_W'(PAY_MAX)));

    assert_sync_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 3'(PK_SYNC)) |-> (pkt_len == '0));

    assert_atom_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 3'(PK_ATOM)) |->
            (atom_count == ACNT_W'(3) || atom_count == ACNT_W'(4)));

    assert_long64_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 3'(PK_LADDR64)) |-> (pkt_len == LEN_W'(8)));

    assert_ctx_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 3'(PK_ACTX64)) |-> (pkt_len == LEN_W'(9)));

endmodule

// File: tb/tb_trc_pkt_parser.sv
`timescale 1ns/1ps
module tb_trc_pkt_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, synced, pkt_valid, err;
    logic [2:0]  pkt_kind;
    logic [3:0]  pkt_len;
    logic [71:0] pkt_payload;
    logic [2:0]  atom_count;
    logic [3:0]  atom_flags;

    int checks = 0;
    int fails  = 0;
    bit gaps   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    trc_pkt_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .synced(synced), .pkt_valid(pkt_valid),
        .pkt_kind(pkt_kind), .pkt_len(pkt_len), .pkt_payload(pkt_payload),
        .atom_count(atom_count), .atom_flags(atom_flags), .err(err)
    );

    typedef struct {
        bit          is_err;
        logic [2:0]  kind;
        logic [3:0]  len;
        logic [71:0] pay;
        logic [2:0]  acnt;
        logic [3:0]  ae;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (gaps) begin
            in_data = 8'h80;  // junk while invalid
            @(negedge clk);
        end
    endtask

    task automatic want(input bit e, input logic [2:0] k, input int n, input logic [71:0] p,
                        input logic [2:0] ac, input logic [3:0] af, input string tag);
        exp_t x;
        x.is_err = e; x.kind = k; x.len = 4'(n); x.pay = p;
        x.acnt = ac; x.ae = af; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic do_sync(input string tag);
        want(0, 3'd0, 0, '0, 3'd0, 4'd0, tag);
        for (int i = 0; i < 11; i++) put_byte(8'h00);
        put_byte(8'h80);
    endtask

    task automatic do_atom(input logic [7:0] h, input logic [2:0] ac, input logic [3:0] af, input string tag);
        want(0, 3'd3, 0, '0, ac, af, tag);
        put_byte(h);
    endtask

    task automatic do_fixed(input logic [7:0] h, input logic [2:0] k, input int n, input logic [71:0] p, input string tag);
        want(0, k, n, p, 3'd0, 4'd0, tag);
        put_byte(h);
        for (int i = 0; i < n; i++) put_byte(p[8*i +: 8]);
    endtask

    task automatic do_var(input logic [7:0] h, input logic [2:0] k, input logic [7:0] bs[$], input string tag);
        logic [71:0] p = '0;
        foreach (bs[i]) p[8*i +: 8] = bs[i];
        want(0, k, bs.size(), p, 3'd0, 4'd0, tag);
        put_byte(h);
        foreach (bs[i]) put_byte(bs[i]);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (pkt_valid || err)) begin
                exp_t e;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R13 unexpected strobe: actual valid=%b err=%b kind=%0d expected none",
                             pkt_valid, err, pkt_kind);
                end else begin
                    e = exp_q.pop_front();
                    if (e.is_err != err ||
                        (!err && (pkt_kind != e.kind || pkt_len != e.len || pkt_payload != e.pay ||
                                  atom_count != e.acnt || atom_flags != e.ae))) begin
                        fails++;
                        $display("FAIL %s: actual err=%b kind=%0d len=%0d pay=%h atoms=%0d/%b expected err=%b kind=%0d len=%0d pay=%h atoms=%0d/%b",
                                 e.tag, err, pkt_kind, pkt_len, pkt_payload, atom_count, atom_flags,
                                 e.is_err, e.kind, e.len, e.pay, e.acnt, e.ae);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] bs[$];
        repeat (3) @(negedge clk);
        check(!synced && !pkt_valid && !err && !in_ready, "R1 reset state",
              {synced, pkt_valid, err, in_ready}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

        // R2: junk and a short run are ignored
        put_byte(8'h55); put_byte(8'h80);
        for (int i = 0; i < 10; i++) put_byte(8'h00);
        put_byte(8'h80);
        put_byte(8'h04);
        check(synced == 1'b0, "R2 short run keeps hunting", synced, 0);
        put_byte(8'h00);
        do_sync("R2 alignment found");
        check(synced == 1'b1, "R2 synced after alignment", synced, 1);

        // R9 trace info
        bs = '{8'h01, 8'h00};               do_var(8'h01, 3'd1, bs, "R9 one field");
        bs = '{8'h03, 8'h81, 8'h05, 8'h7F}; do_var(8'h01, 3'd1, bs, "R9 two fields");
        bs = '{8'h00};                      do_var(8'h01, 3'd1, bs, "R9 no field");

        // R3 trace on and strobe latency
        want(0, 3'd2, 0, '0, 3'd0, 4'd0, "R3 trace on");
        put_byte(8'h04);
        check(pkt_valid == 1'b1, "R3 strobe one cycle after last byte", pkt_valid, 1);

        // R7 address with context
        do_fixed(8'h85, 3'd7, 9, {8'h31, 64'hFFFF_8000_10AB_FFC4}, "R7 address plus context");

        // R4 / R5 atoms
        do_atom(8'hFC, 3'd3, 4'b0100, "R4 NNE");
        do_atom(8'hDE, 3'd4, 4'b0101, "R5 ENEN");
        do_atom(8'hFD, 3'd3, 4'b0101, "R4 ENE");
        do_atom(8'hFF, 3'd3, 4'b0111, "R4 EEE");
        do_atom(8'hDC, 3'd4, 4'b0111, "R5 EEEN");
        do_atom(8'hFA, 3'd3, 4'b0010, "R4 NEN");
        do_atom(8'hF8, 3'd3, 4'b0000, "R4 NNN");
        do_atom(8'hFB, 3'd3, 4'b0011, "R4 EEN");
        do_atom(8'hDD, 3'd4, 4'b0000, "R5 NNNN");
        do_atom(8'hDF, 3'd4, 4'b1010, "R5 NENE");

        // R6 long addresses
        do_fixed(8'h9D, 3'd6, 8, {8'h00, 64'hFFFF_8000_10AD_3DE8}, "R6 long 64");
        do_fixed(8'h9A, 3'd5, 4, 72'h10E7_E1C8, "R6 long 32");

        // R8 short address, with gaps between bytes
        gaps = 1'b1;
        bs = '{8'h12};        do_var(8'h95, 3'd4, bs, "R8 short one byte");
        bs = '{8'h85, 8'h03}; do_var(8'h95, 3'd4, bs, "R8 short two bytes");
        bs = '{8'h81, 8'h81}; do_var(8'h95, 3'd4, bs, "R8 second byte always ends");
        gaps = 1'b0;

        // R11 in-stream alignment, good then broken
        do_sync("R11 in-stream alignment");
        check(synced == 1'b1, "R11 still synced", synced, 1);
        want(1, 3'd0, 0, '0, 3'd0, 4'd0, "R11 broken alignment");
        put_byte(8'h00); put_byte(8'h00); put_byte(8'h80);
        check(synced == 1'b0, "R11 broken alignment unsyncs", synced, 0);
        do_sync("R11 resync");

        // R10 unknown header
        want(1, 3'd0, 0, '0, 3'd0, 4'd0, "R10 bad header");
        put_byte(8'h02);
        check(synced == 1'b0, "R10 unsynced after bad header", synced, 0);
        put_byte(8'h04);
        put_byte(8'hFF);
        check(synced == 1'b0, "R10 bytes discarded while hunting", synced, 0);
        do_sync("R10 resync");

        // R12 boundary: nine bytes legal, ten is an error
        bs = '{8'h0F, 8'h81, 8'h01, 8'h81, 8'h01, 8'h81, 8'h01, 8'h81, 8'h01};
        do_var(8'h01, 3'd1, bs, "R12 nine-byte trace info");
        want(1, 3'd0, 0, '0, 3'd0, 4'd0, "R12 overlong trace info");
        put_byte(8'h01); put_byte(8'h0F);
        for (int i = 0; i < 9; i++) put_byte(8'h80);
        check(synced == 1'b0, "R12 overflow unsyncs", synced, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R13 all expected strobes seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule